// File: doc/BRIEF.md
# Pipelined ADC Stage-Weight Calibration Sequencer

This block measures the true weights of the 1.5-bit stages of a pipelined converter. It visits stages one at a time, starting from the highest stage selected for calibration and working down to stage 0. For the stage under test, it tells the analog side to hold that stage's input at one of its two internal decision levels. It then forces the stage comparator to a chosen decision and averages the corrected code coming back from the stages behind it. Four such averaged codes give two weights per stage. Both weights go out on a register-file write port before the next stage begins.

Software or a higher-level controller pulses a start request. It selects the top stage, the averaging depth (2^k samples per code) and the number of samples to throw away after each change of forcing. It then waits for the one-cycle done pulse. The analog stage, the comparators and the correction datapath that produce the back-end code sit outside this block.

Top module: `adccal_seq`

## Requirements
- R1: After reset, busy_o, done_o, wr_en_o and drive_en_o are all 0.
- R2: A start_i pulse while idle begins a run at stage top_stage_i. Stages are then calibrated one at a time in descending order down to stage 0, and wr_stage_o reports each stage in that order.
- R3: For each stage, exactly two writes occur on consecutive cycles after its four measurements: first w0 (wr_sel_o = 0), then w2 (wr_sel_o = 1).
- R4: w0 equals S1 minus S0, modulo 2^16. S0 is measured with level_hi_o = 0 and force_dec_o = 0. S1 is measured with level_hi_o = 0 and force_dec_o = 1. force_dec_o is a 2-bit binary decision value of 0, 1 or 2.
- R5: w2 equals S2 minus S3, modulo 2^16. S2 is measured with level_hi_o = 1 and force_dec_o = 2. S3 is measured with level_hi_o = 1 and force_dec_o = 1. The measurements run in the order S0, S1, S2, S3.
- R6: Each Sx is the sum of 2^k accepted back-end samples shifted right by k, where k = avg_log_i.
- R7: After each change of forcing, the first flush_len_i valid samples are discarded before accumulation starts.
- R8: done_o is high for exactly one cycle, the cycle right after stage 0's w2 write. drive_en_o is 0 while done_o is high and stays 0 afterwards.
- R9: A start_i pulse received while busy_o is high has no effect on the running sequence.
- R10: A top_stage_i value of NUM_STG or more is treated as NUM_STG-1 (stage 6 by default).
- R11: Only cycles with code_valid_i high supply samples, for both discarding and accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, honoured only when idle |
| top_stage_i | input | STG_W | Highest stage to calibrate |
| avg_log_i | input | LOG_W | k: 2^k samples averaged per code |
| flush_len_i | input | FLUSH_W | Valid samples discarded after each forcing change |
| code_valid_i | input | 1 | Back-end code sample valid |
| code_i | input | CODE_W | Corrected back-end code |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| drive_en_o | output | 1 | Apply decision level and forced decision |
| stage_sel_o | output | STG_W | Stage under test |
| level_hi_o | output | 1 | 0 selects the lower decision level, 1 the upper |
| force_dec_o | output | 2 | Forced comparator decision (0, 1 or 2) |
| wr_en_o | output | 1 | Weight write strobe |
| wr_sel_o | output | 1 | 0 writes w0, 1 writes w2 |
| wr_stage_o | output | STG_W | Stage index of the written weight |
| wr_data_o | output | CODE_W | Weight value |

## Verification
Several rules are checked on every cycle. The forcing legality holds for each level: decision 2 never appears at the lower level, and decision 0 never appears at the upper level. The forcing stays constant across each averaging window. Each w2 write is paired with a w0 write for the same stage. The stage index never rises mid-run, and the done pulse is single, follows stage 0's last write, and releases the forcing. The numerical results can only be shown by the bench scenarios. These results are the weight values produced by averaging with alternating noise, the discarding of stale pipeline samples after each forcing change, the clamping of an oversized top stage, and the immunity to a second start.

// File: rtl/adccal_pkg.sv
package adccal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_FLUSH,
    ST_ACCUM,
    ST_STORE,
    ST_WR0,
    ST_WR2,
    ST_DONE
  } cal_state_e;

  localparam int MEAS_N = 4;

  // Measurements 0,1 sit at the lower level; 2,3 at the upper level.
  function automatic logic meas_upper(input logic [1:0] m);
    return m[1];
  endfunction

  // Forced decision per measurement: S0->0, S1->1, S2->2, S3->1.
  function automatic logic [1:0] meas_force(input logic [1:0] m);
    case (m)
      2'd0:    return 2'd0;
      2'd1:    return 2'd1;
      2'd2:    return 2'd2;
      default: return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/adccal_avg.sv
module adccal_avg #(
  parameter int CODE_W  = 16,
  parameter int ACC_W   = 32,
  parameter int LOG_W   = 4,
  parameter int FLUSH_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               flush_en_i,
  input  logic               acc_en_i,
  input  logic               code_valid_i,
  input  logic [CODE_W-1:0]  code_i,
  input  logic [FLUSH_W-1:0] flush_len_i,
  input  logic [LOG_W-1:0]   avg_log_i,
  output logic               flush_done_o,
  output logic               acc_done_o,
  output logic [CODE_W-1:0]  avg_o
);

  // Sample counter must hold 2^(2^LOG_W - 1).
  localparam int CNT_W = (1 << LOG_W);

  logic [FLUSH_W-1:0] lat_q;
  logic [CNT_W-1:0]   cyc_q;
  logic [ACC_W-1:0]   acc_q;
  logic [CNT_W-1:0]   cyc_tgt;

  function automatic logic [CODE_W-1:0] shift_avg(input logic [ACC_W-1:0] s,
                                                  input logic [LOG_W-1:0] k);
    return CODE_W'(s >> k);
  endfunction

  assign cyc_tgt      = CNT_W'(1) << avg_log_i;
  assign flush_done_o = flush_en_i && (lat_q == flush_len_i);
  assign acc_done_o   = acc_en_i && (cyc_q == cyc_tgt);
  assign avg_o        = shift_avg(acc_q, avg_log_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      cyc_q <= '0;
      acc_q <= '0;
    end else if (clr_i) begin
      lat_q <= '0;
      cyc_q <= '0;
      acc_q <= '0;
    end else begin
      if (flush_en_i && code_valid_i && !flush_done_o)
        lat_q <= lat_q + FLUSH_W'(1);
      if (acc_en_i && code_valid_i && !acc_done_o) begin
        acc_q <= acc_q + ACC_W'(code_i);
        cyc_q <= cyc_q + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/adccal_wts.sv
module adccal_wts #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              store_i,
  input  logic [1:0]        meas_i,
  input  logic [CODE_W-1:0] avg_i,
  output logic [CODE_W-1:0] w0_o,
  output logic [CODE_W-1:0] w2_o
);
  import adccal_pkg::*;

  logic [MEAS_N-1:0][CODE_W-1:0] slot_val;

  function automatic logic [CODE_W-1:0] code_diff(input logic [CODE_W-1:0] a,
                                                  input logic [CODE_W-1:0] b);
    return a - b;
  endfunction

  for (genvar i = 0; i < MEAS_N; i++) begin : g_slot
    logic [CODE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          q <= '0;
      else if (store_i && meas_i == 2'(i)) q <= avg_i;
    end
    assign slot_val[i] = q;
  end

  assign w0_o = code_diff(slot_val[1], slot_val[0]);
  assign w2_o = code_diff(slot_val[2], slot_val[3]);

endmodule

// File: rtl/adccal_fsm.sv
module adccal_fsm #(
  parameter int NUM_STG = 7,
  parameter int STG_W   = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [STG_W-1:0]       top_stage_i,
  input  logic                   flush_done_i,
  input  logic                   acc_done_i,
  output adccal_pkg::cal_state_e state_o,
  output logic [STG_W-1:0]       stage_o,
  output logic [1:0]             meas_o
);
  import adccal_pkg::*;

  localparam logic [STG_W-1:0] LAST_STG = STG_W'(NUM_STG - 1);

  cal_state_e       st_q, st_d;
  logic [STG_W-1:0] stg_q, stg_d;
  logic [1:0]       m_q, m_d;

  function automatic logic [STG_W-1:0] clamp_stage(input logic [STG_W-1:0] s);
    return (s > LAST_STG) ? LAST_STG : s;
  endfunction

  always_comb begin
    st_d  = st_q;
    stg_d = stg_q;
    m_d   = m_q;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d  = ST_SETUP;
        stg_d = clamp_stage(top_stage_i);
        m_d   = 2'd0;
      end
      ST_SETUP: st_d = ST_FLUSH;
      ST_FLUSH: if (flush_done_i) st_d = ST_ACCUM;
      ST_ACCUM: if (acc_done_i)   st_d = ST_STORE;
      ST_STORE: begin
        if (m_q == 2'(MEAS_N - 1)) begin
          st_d = ST_WR0;
        end else begin
          m_d  = m_q + 2'd1;
          st_d = ST_SETUP;
        end
      end
      ST_WR0: st_d = ST_WR2;
      ST_WR2: begin
        if (stg_q == '0) begin
          st_d = ST_DONE;
        end else begin
          stg_d = stg_q - STG_W'(1);
          m_d   = 2'd0;
          st_d  = ST_SETUP;
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      stg_q <= '0;
      m_q   <= '0;
    end else begin
      st_q  <= st_d;
      stg_q <= stg_d;
      m_q   <= m_d;
    end
  end

  assign state_o = st_q;
  assign stage_o = stg_q;
  assign meas_o  = m_q;

endmodule

// File: rtl/adccal_seq.sv
module adccal_seq #(
  parameter int NUM_STG = 7,
  parameter int CODE_W  = 16,
  parameter int ACC_W   = 32,
  parameter int LOG_W   = 4,
  parameter int FLUSH_W = 8,
  localparam int STG_W  = $clog2(NUM_STG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [STG_W-1:0]   top_stage_i,
  input  logic [LOG_W-1:0]   avg_log_i,
  input  logic [FLUSH_W-1:0] flush_len_i,
  input  logic               code_valid_i,
  input  logic [CODE_W-1:0]  code_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               drive_en_o,
  output logic [STG_W-1:0]   stage_sel_o,
  output logic               level_hi_o,
  output logic [1:0]         force_dec_o,
  output logic               wr_en_o,
  output logic               wr_sel_o,
  output logic [STG_W-1:0]   wr_stage_o,
  output logic [CODE_W-1:0]  wr_data_o
);
  import adccal_pkg::*;

  cal_state_e        state_w;
  logic [STG_W-1:0]  stage_w;
  logic [1:0]        meas_w;
  logic              flush_done_w;
  logic              acc_done_w;
  logic              store_w;
  logic [CODE_W-1:0] avg_w;
  logic [CODE_W-1:0] w0_w;
  logic [CODE_W-1:0] w2_w;

  adccal_fsm #(.NUM_STG(NUM_STG), .STG_W(STG_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .top_stage_i  (top_stage_i),
    .flush_done_i (flush_done_w),
    .acc_done_i   (acc_done_w),
    .state_o      (state_w),
    .stage_o      (stage_w),
    .meas_o       (meas_w)
  );

  adccal_avg #(.CODE_W(CODE_W), .ACC_W(ACC_W), .LOG_W(LOG_W), .FLUSH_W(FLUSH_W)) u_avg (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (state_w == ST_SETUP),
    .flush_en_i   (state_w == ST_FLUSH),
    .acc_en_i     (state_w == ST_ACCUM),
    .code_valid_i (code_valid_i),
    .code_i       (code_i),
    .flush_len_i  (flush_len_i),
    .avg_log_i    (avg_log_i),
    .flush_done_o (flush_done_w),
    .acc_done_o   (acc_done_w),
    .avg_o        (avg_w)
  );

  assign store_w = (state_w == ST_STORE);

  adccal_wts #(.CODE_W(CODE_W)) u_wts (
    .clk     (clk),
    .rst_n   (rst_n),
    .store_i (store_w),
    .meas_i  (meas_w),
    .avg_i   (avg_w),
    .w0_o    (w0_w),
    .w2_o    (w2_w)
  );

  assign busy_o      = (state_w != ST_IDLE);
  assign done_o      = (state_w == ST_DONE);
  assign drive_en_o  = (state_w != ST_IDLE) && (state_w != ST_DONE);
  assign stage_sel_o = stage_w;
  assign level_hi_o  = drive_en_o && meas_upper(meas_w);
  assign force_dec_o = drive_en_o ? meas_force(meas_w) : 2'd0;
  assign wr_en_o     = (state_w == ST_WR0) || (state_w == ST_WR2);
  assign wr_sel_o    = (state_w == ST_WR2);
  assign wr_stage_o  = stage_w;
  assign wr_data_o   = wr_sel_o ? w2_w : w0_w;

endmodule

// File: rtl/adccal_seq_chk.sv
module adccal_seq_chk #(
  parameter int NUM_STG = 7,
  parameter int STG_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy_o,
  input logic             done_o,
  input logic             drive_en_o,
  input logic [STG_W-1:0] stage_sel_o,
  input logic             level_hi_o,
  input logic [1:0]       force_dec_o,
  input logic             wr_en_o,
  input logic             wr_sel_o,
  input logic             flush_done,
  input logic             acc_done
);
  localparam logic [STG_W-1:0] LAST_STG = STG_W'(NUM_STG - 1);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!wr_en_o && !drive_en_o));

  p_wr_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_sel_o) |-> ($past(wr_en_o) && !$past(wr_sel_o) &&
                               $past(stage_sel_o) == stage_sel_o));

  p_lower_force_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o && !level_hi_o) |-> (force_dec_o != 2'd2));

  p_upper_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en_o && level_hi_o) |-> (force_dec_o != 2'd0));

  p_hold_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> ($stable(force_dec_o) && $stable(level_hi_o) && $stable(stage_sel_o)));

  p_flush_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && !busy_o));

  p_done_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!drive_en_o && !wr_en_o));

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(wr_en_o) && $past(wr_sel_o) && $past(stage_sel_o) == '0));

  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> (stage_sel_o <= $past(stage_sel_o)));

  p_stage_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (stage_sel_o <= LAST_STG));

endmodule

bind adccal_seq adccal_seq_chk #(.NUM_STG(NUM_STG), .STG_W(STG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .drive_en_o  (drive_en_o),
  .stage_sel_o (stage_sel_o),
  .level_hi_o  (level_hi_o),
  .force_dec_o (force_dec_o),
  .wr_en_o     (wr_en_o),
  .wr_sel_o    (wr_sel_o),
  .flush_done  (flush_done_w),
  .acc_done    (acc_done_w)
);

// File: tb/adccal_seq_bench.sv
`timescale 1ns/1ps
module adccal_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [2:0]  top_stage_i = '0;
  logic [3:0]  avg_log_i = '0;
  logic [7:0]  flush_len_i = 8'd4;
  logic        code_valid_i = 1'b0;
  logic [15:0] code_i;
  logic        busy_o, done_o, drive_en_o, level_hi_o, wr_en_o, wr_sel_o;
  logic [2:0]  stage_sel_o, wr_stage_o;
  logic [1:0]  force_dec_o;
  logic [15:0] wr_data_o;

  always #5 clk = ~clk;

  adccal_seq u_adccal_seq (.*);

  // Analog model state
  logic [15:0] lo_b [8];
  logic [15:0] g0   [8];
  logic [15:0] hi_b [8];
  logic [15:0] g2   [8];
  logic [15:0] pipe0 = '0, pipe1 = '0, pipe2 = '0;
  logic        par = 1'b0;
  int          k_cur = 0;

  int nchk = 0, nfail = 0;
  int nw = 0, ndone = 0, done_bad = 0;
  int wl_stage [32];
  int wl_sel   [32];
  logic [15:0] wl_data [32];

  function automatic logic [15:0] model_code(input logic [2:0] s, input logic hi,
                                             input logic [1:0] f, input logic en);
    if (!en)          return 16'h0100;
    if (!hi && f == 0) return lo_b[s];
    if (!hi)           return lo_b[s] + g0[s];
    if (f == 1)        return hi_b[s];
    return hi_b[s] + g2[s];
  endfunction

  function automatic logic [15:0] exp_weight(input logic [15:0] a, input logic [15:0] b);
    return a - b;
  endfunction

  always @(posedge clk) begin
    pipe0 <= model_code(stage_sel_o, level_hi_o, force_dec_o, drive_en_o);
    pipe1 <= pipe0;
    pipe2 <= pipe1;
    if (code_valid_i) par <= ~par;
  end
  assign code_i = pipe2 + ((k_cur == 0) ? 16'd0 : (par ? 16'd1 : 16'hFFFF));

  initial forever begin
    @(negedge clk);
    code_valid_i = ($urandom_range(3) != 0);
  end

  always @(negedge clk) begin
    if (wr_en_o && nw < 32) begin
      wl_stage[nw] = int'(wr_stage_o);
      wl_sel[nw]   = int'(wr_sel_o);
      wl_data[nw]  = wr_data_o;
      nw++;
    end
    if (done_o) begin
      ndone++;
      if (drive_en_o) done_bad++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run_cal(input int top, input int k, input int fl, input bit poke,
                         input bit neg);
    int eff;
    int cyc;
    eff = (top > 6) ? 6 : top;
    for (int s = 0; s < 8; s++) begin
      lo_b[s] = 16'(2000 + $urandom_range(20000));
      hi_b[s] = 16'(30000 + $urandom_range(20000));
      g0[s]   = neg ? 16'(-(400 + int'($urandom_range(1000))))
                    : 16'(int'($urandom_range(3000)) - 1500);
      g2[s]   = neg ? 16'(-(300 + int'($urandom_range(900))))
                    : 16'(int'($urandom_range(3000)) - 1500);
    end
    @(negedge clk);
    nw = 0; ndone = 0; done_bad = 0;
    k_cur = k;
    avg_log_i = 4'(k);
    flush_len_i = 8'(fl);
    top_stage_i = 3'(top);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    cyc = 0;
    while (ndone == 0) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 60) begin
        top_stage_i = 3'd1;       // R9: restart attempt while busy
        start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
      if (poke && cyc == 60) chk(busy_o == 1'b1, "R9 busy before poke", int'(busy_o), 1);
    end
    repeat (3) @(negedge clk);
    chk(drive_en_o == 1'b0, "R8 forcing released after done", int'(drive_en_o), 0);
    chk(busy_o == 1'b0, "R8 idle after done", int'(busy_o), 0);
    chk(ndone == 1, "R8 done pulse count", ndone, 1);
    chk(done_bad == 0, "R8 forcing low during done", done_bad, 0);
    chk(nw == 2 * (eff + 1), (top > 6) ? "R10 clamped write count" : "R2 write count",
        nw, 2 * (eff + 1));
    for (int i = 0; i < nw && i < 2 * (eff + 1); i++) begin
      int s;
      logic [15:0] e;
      s = eff - i / 2;
      chk(wl_stage[i] == s, "R2 descending stage order", wl_stage[i], s);
      chk(wl_sel[i] == i % 2, "R3 w0 then w2", wl_sel[i], i % 2);
      if (i % 2 == 0) begin
        e = exp_weight(lo_b[s] + g0[s], lo_b[s]);
        chk(wl_data[i] == e, "R4 w0 value (R6 R7 R11 path)", int'(wl_data[i]), int'(e));
      end else begin
        e = exp_weight(hi_b[s] + g2[s], hi_b[s]);
        chk(wl_data[i] == e, "R5 w2 value (R6 R7 R11 path)", int'(wl_data[i]), int'(e));
      end
    end
  endtask

  task automatic finish_up;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    void'($urandom(32'd7391));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy_o == 1'b0, "R1 busy at reset", int'(busy_o), 0);
    chk(done_o == 1'b0, "R1 done at reset", int'(done_o), 0);
    chk(wr_en_o == 1'b0, "R1 wr_en at reset", int'(wr_en_o), 0);
    chk(drive_en_o == 1'b0, "R1 drive_en at reset", int'(drive_en_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o == 1'b0, "R1 idle after reset release", int'(busy_o), 0);

    run_cal(0, 0, 4, 1'b0, 1'b0);  // single stage, k=0 (R6 edge)
    run_cal(6, 2, 5, 1'b0, 1'b0);  // full depth, averaging
    run_cal(7, 1, 4, 1'b0, 1'b0);  // R10 clamp
    run_cal(3, 3, 8, 1'b0, 1'b1);  // negative weights, wrap (R4 R5)
    run_cal(5, 2, 6, 1'b1, 1'b0);  // R9 start while busy
    for (int r = 0; r < 6; r++)
      run_cal(int'($urandom_range(7)), int'($urandom_range(4)),
              4 + int'($urandom_range(4)), 1'b0, 1'b0);
    finish_up();
  end

endmodule